// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns the sampled levels of a small I/O port into one interrupt request. For each pin, software chooses one of three sensing modes: level, one edge, or both edges. Software also chooses the polarity. The polarity bit selects high or rising in one setting, and low or falling in the other. Each detection sets a sticky bit in a raw status word. Software clears those bits by writing ones to a clear register. A mask register selects which raw bits may drive the request line, and the request is the registered OR of the masked bits.

The block sits behind a bus decoder and a pin synchroniser, and neither of those is part of it. The decoder supplies a single-cycle write strobe with an address and data, plus a read address; read data returns combinationally. The synchroniser supplies clean pin levels and a per-pin direction vector. Edge sensing looks only at pins marked as inputs. Level sensing follows the pin level whatever its direction. While a level condition holds, its raw bit is set again every cycle, so a clear has no lasting effect until the pin changes.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, the sense, both-edge, polarity, mask and raw status registers are all 0, every register read returns 0, and `irq` is 0.
- R2: The registers sit at fixed word offsets: sense 0x404, both-edge 0x408, polarity 0x40C and mask 0x410 (read/write), raw status 0x414 and masked status 0x418 (read-only), clear 0x41C (write-only, reads 0). Writes to the read-only offsets change nothing, and any other offset reads 0.
- R3: A pin whose sense bit is 0, both-edge bit is 0 and polarity bit is 1 sets its raw bit one clock after a 0-to-1 change, and not after a 1-to-0 change.
- R4: With the sense bit 0, both-edge bit 0 and polarity bit 0, the raw bit is set by a 1-to-0 change and not by a 0-to-1 change.
- R5: With the sense bit 0 and the both-edge bit 1, either direction of change sets the raw bit; the polarity bit plays no part.
- R6: In edge mode, a change on a pin whose `pin_is_input` bit is 0 never sets its raw bit.
- R7: With the sense bit 1, the raw bit is set in every cycle in which the pin level equals the polarity bit, whatever the pin's direction; a clear during that condition leaves the bit set.
- R8: Writing the clear register clears each raw bit whose data bit is 1; raw bits whose data bit is 0 are kept.
- R9: If a clear and a new detection hit the same raw bit in the same cycle, the bit stays set.
- R10: The masked status read returns raw status AND mask.
- R11: `irq` is registered: it goes to 1 one clock after any masked bit becomes 1, and goes to 0 one clock after no masked bit is 1 (after a clear or a mask change).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPIN | Synchronised pin levels |
| pin_is_input | input | NPIN | 1 marks a pin as an input (edge sensing allowed) |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | AW | Write byte offset |
| wr_data | input | NPIN | Write data |
| rd_addr | input | AW | Read byte offset |
| rd_data | output | NPIN | Combinational read data |
| irq | output | 1 | Combined interrupt request |

## Verification
A pin change applied before clock edge k is compared with the stored previous level at that edge, so the raw status read shows it from edge k onward; `irq` follows one edge later, at k+1. A register write takes effect at the edge that samples its strobe. Sensing at that same edge still uses the old configuration, so a mask write leaves `irq` at its old value for one more cycle. The bench drives every input on the falling clock edge and reads results at the next falling edge, or the one after it for `irq`. It checks both the value before and the value after each edge at which a result is due.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // Register offsets within the port's window (byte addresses)
   localparam logic [11:0] OFS_SENSE  = 12'h404;
   localparam logic [11:0] OFS_BOTH   = 12'h408;
   localparam logic [11:0] OFS_POL    = 12'h40C;
   localparam logic [11:0] OFS_MASK   = 12'h410;
   localparam logic [11:0] OFS_RAW    = 12'h414;
   localparam logic [11:0] OFS_MASKED = 12'h418;
   localparam logic [11:0] OFS_CLEAR  = 12'h41C;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_SENSE,
      SEL_BOTH,
      SEL_POL,
      SEL_MASK,
      SEL_RAW,
      SEL_MASKED,
      SEL_CLEAR
   } reg_sel_e;

   // Per-pin configuration seen by one detection lane
   typedef struct packed {
      logic level;   // 1: level sensing, 0: edge sensing
      logic both;    // 1: any edge
      logic pol;     // matching level / edge direction
   } lane_cfg_t;

endpackage

// File: rtl/gpio_irq_lane.sv
module gpio_irq_lane
   import gpio_irq_pkg::*;
(
   input  logic      pin_now,
   input  logic      pin_prev,
   input  logic      is_input,
   input  lane_cfg_t cfg,
   output logic      hit
);

   logic changed;
   logic at_pol;

   assign changed = is_input & (pin_now ^ pin_prev);
   assign at_pol  = (pin_now == cfg.pol);

   always_comb begin
      if (cfg.level) begin
         hit = at_pol;
      end else if (cfg.both) begin
         hit = changed;
      end else begin
         hit = changed & at_pol;
      end
   end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int NPIN = 8,
   parameter int AW   = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [NPIN-1:0] wr_data,
   input  logic [AW-1:0]   rd_addr,
   input  logic [NPIN-1:0] raw_q,
   output logic [NPIN-1:0] sense_q,
   output logic [NPIN-1:0] both_q,
   output logic [NPIN-1:0] pol_q,
   output logic [NPIN-1:0] mask_q,
   output logic [NPIN-1:0] clr_vec,
   output logic [NPIN-1:0] rd_data
);

   function automatic reg_sel_e sel_of(input logic [AW-1:0] a);
      reg_sel_e s;
      s = SEL_NONE;
      if (a == AW'(OFS_SENSE))  s = SEL_SENSE;
      if (a == AW'(OFS_BOTH))   s = SEL_BOTH;
      if (a == AW'(OFS_POL))    s = SEL_POL;
      if (a == AW'(OFS_MASK))   s = SEL_MASK;
      if (a == AW'(OFS_RAW))    s = SEL_RAW;
      if (a == AW'(OFS_MASKED)) s = SEL_MASKED;
      if (a == AW'(OFS_CLEAR))  s = SEL_CLEAR;
      return s;
   endfunction

   reg_sel_e wsel;
   reg_sel_e rsel;

   assign wsel = wr_en ? sel_of(wr_addr) : SEL_NONE;
   assign rsel = sel_of(rd_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q <= '0;
         both_q  <= '0;
         pol_q   <= '0;
         mask_q  <= '0;
      end else begin
         case (wsel)
            SEL_SENSE: sense_q <= wr_data;
            SEL_BOTH:  both_q  <= wr_data;
            SEL_POL:   pol_q   <= wr_data;
            SEL_MASK:  mask_q  <= wr_data;
            default: ;
         endcase
      end
   end

   assign clr_vec = (wsel == SEL_CLEAR) ? wr_data : '0;

   always_comb begin
      case (rsel)
         SEL_SENSE:  rd_data = sense_q;
         SEL_BOTH:   rd_data = both_q;
         SEL_POL:    rd_data = pol_q;
         SEL_MASK:   rd_data = mask_q;
         SEL_RAW:    rd_data = raw_q;
         SEL_MASKED: rd_data = raw_q & mask_q;
         default:    rd_data = '0;
      endcase
   end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
   parameter int NPIN    = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] hit,
   input  logic [NPIN-1:0] clr_vec,
   input  logic [NPIN-1:0] mask_q,
   output logic [NPIN-1:0] raw_q,
   output logic            irq
);

   logic any_masked;

   // New detections override a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0;
      end else begin
         raw_q <= (raw_q & ~clr_vec) | hit;
      end
   end

   assign any_masked = |(raw_q & mask_q);

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= 1'b0;
            end else begin
               irq_q <= any_masked;
            end
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = any_masked;
      end
   endgenerate

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gpio_irq_pkg::*;
#(
   parameter int NPIN    = 8,
   parameter int AW      = 12,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] pin_in,
   input  logic [NPIN-1:0] pin_is_input,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [NPIN-1:0] wr_data,
   input  logic [AW-1:0]   rd_addr,
   output logic [NPIN-1:0] rd_data,
   output logic            irq
);

   generate
      if (NPIN < 1 || NPIN > 32) begin : g_bad_npin
         $error("gpio_irq_detect: NPIN must lie in 1..32");
      end
      if (AW < 12) begin : g_bad_aw
         $error("gpio_irq_detect: AW must be at least 12");
      end
   endgenerate

   logic [NPIN-1:0] sense_q;
   logic [NPIN-1:0] both_q;
   logic [NPIN-1:0] pol_q;
   logic [NPIN-1:0] mask_q;
   logic [NPIN-1:0] clr_vec;
   logic [NPIN-1:0] raw_q;
   logic [NPIN-1:0] hit;
   logic [NPIN-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
      end else begin
         prev_q <= pin_in;
      end
   end

   gpio_irq_regs #(.NPIN(NPIN), .AW(AW)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .raw_q   (raw_q),
      .sense_q (sense_q),
      .both_q  (both_q),
      .pol_q   (pol_q),
      .mask_q  (mask_q),
      .clr_vec (clr_vec),
      .rd_data (rd_data)
   );

   generate
      for (genvar i = 0; i < NPIN; i++) begin : g_lane
         lane_cfg_t cfg;
         assign cfg.level = sense_q[i];
         assign cfg.both  = both_q[i];
         assign cfg.pol   = pol_q[i];
         gpio_irq_lane lane_i (
            .pin_now  (pin_in[i]),
            .pin_prev (prev_q[i]),
            .is_input (pin_is_input[i]),
            .cfg      (cfg),
            .hit      (hit[i])
         );
      end
   endgenerate

   gpio_irq_status #(.NPIN(NPIN), .IRQ_REG(IRQ_REG)) status_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .clr_vec (clr_vec),
      .mask_q  (mask_q),
      .raw_q   (raw_q),
      .irq     (irq)
   );

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
   import gpio_irq_pkg::*;
#(
   parameter int NPIN    = 8,
   parameter int AW      = 12,
   parameter bit IRQ_REG = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NPIN-1:0] pin_in,
   input logic [NPIN-1:0] pin_is_input,
   input logic            wr_en,
   input logic [AW-1:0]   wr_addr,
   input logic [NPIN-1:0] wr_data,
   input logic            irq,
   input logic [NPIN-1:0] sense_q,
   input logic [NPIN-1:0] pol_q,
   input logic [NPIN-1:0] mask_q,
   input logic [NPIN-1:0] raw_q,
   input logic [NPIN-1:0] hit
);

   logic [NPIN-1:0] clr_seen;
   logic [NPIN-1:0] lvl_cond;
   logic [NPIN-1:0] prev_pin;

   assign clr_seen = (wr_en && wr_addr == AW'(OFS_CLEAR)) ? wr_data : '0;
   assign lvl_cond = sense_q & ~(pin_in ^ pol_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_pin <= '0;
      else        prev_pin <= pin_in;
   end

   generate
      if (IRQ_REG) begin : g_irq_chk
         AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            (|(raw_q & mask_q)) |=> irq);                                         // R11
         AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            !(|(raw_q & mask_q)) |=> !irq);                                       // R11
      end
   endgenerate

   AST_RAW_ONLY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(raw_q) & ~raw_q) & ~$past(clr_seen)) == '0));            // R8

   AST_DETECT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ((hit & clr_seen) != '0) |=> ((raw_q & $past(hit & clr_seen)) == $past(hit & clr_seen))); // R9

   AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_cond != '0) |=> ((raw_q & $past(lvl_cond)) == $past(lvl_cond)));       // R7

   AST_OUTPUT_PIN_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      ((hit & ~sense_q & ~pin_is_input) == '0));                                  // R6

   AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ((hit & ~sense_q & ~(pin_in ^ prev_pin)) == '0));                           // R3

endmodule

bind gpio_irq_detect gpio_irq_chk #(.NPIN(NPIN), .AW(AW), .IRQ_REG(IRQ_REG)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .pin_in       (pin_in),
   .pin_is_input (pin_is_input),
   .wr_en        (wr_en),
   .wr_addr      (wr_addr),
   .wr_data      (wr_data),
   .irq          (irq),
   .sense_q      (sense_q),
   .pol_q        (pol_q),
   .mask_q       (mask_q),
   .raw_q        (raw_q),
   .hit          (hit)
);

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb_top;

   localparam int NPIN = 8;
   localparam int AW   = 12;

   localparam logic [AW-1:0] A_SENSE  = 12'h404;
   localparam logic [AW-1:0] A_BOTH   = 12'h408;
   localparam logic [AW-1:0] A_POL    = 12'h40C;
   localparam logic [AW-1:0] A_MASK   = 12'h410;
   localparam logic [AW-1:0] A_RAW    = 12'h414;
   localparam logic [AW-1:0] A_MASKED = 12'h418;
   localparam logic [AW-1:0] A_CLEAR  = 12'h41C;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NPIN-1:0] pin_in = '0;
   logic [NPIN-1:0] pin_is_input = '1;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   wr_addr = '0;
   logic [NPIN-1:0] wr_data = '0;
   logic [AW-1:0]   rd_addr = '0;
   logic [NPIN-1:0] rd_data;
   logic            irq;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   gpio_irq_detect #(.NPIN(NPIN), .AW(AW)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .pin_in       (pin_in),
      .pin_is_input (pin_is_input),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .rd_addr      (rd_addr),
      .rd_data      (rd_data),
      .irq          (irq)
   );

   task automatic check(input string req, input string what, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_errors++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   // Called at a falling edge; the write lands at the next rising edge,
   // and the task returns at the falling edge after it.
   task automatic wr(input logic [AW-1:0] a, input logic [NPIN-1:0] d);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [NPIN-1:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic check_reg(input string req, input logic [AW-1:0] a, input logic [NPIN-1:0] exp);
      logic [NPIN-1:0] v;
      rd(a, v);
      check(req, $sformatf("read 0x%0h", a), int'(v), int'(exp));
   endtask

   task automatic cfg(input logic [NPIN-1:0] both, input logic [NPIN-1:0] pol,
                      input logic [NPIN-1:0] mask, input logic [NPIN-1:0] sense);
      wr(A_POL, pol);
      wr(A_BOTH, both);
      wr(A_MASK, mask);
      wr(A_SENSE, sense);
      wr(A_CLEAR, '1);
   endtask

   task automatic t_reset();
      check_reg("R1", A_SENSE, '0);
      check_reg("R1", A_BOTH, '0);
      check_reg("R1", A_POL, '0);
      check_reg("R1", A_MASK, '0);
      check_reg("R1", A_RAW, '0);
      check_reg("R1", A_MASKED, '0);
      check("R1", "irq after reset", int'(irq), 0);
   endtask

   task automatic t_regs();
      wr(A_POL, 8'h96);
      wr(A_BOTH, 8'h3C);
      wr(A_MASK, 8'h0F);
      check_reg("R2", A_POL, 8'h96);
      check_reg("R2", A_BOTH, 8'h3C);
      check_reg("R2", A_MASK, 8'h0F);
      wr(A_SENSE, 8'hA5);
      check_reg("R2", A_SENSE, 8'hA5);
      check_reg("R2", A_CLEAR, '0);
      check_reg("R2", 12'h420, '0);
      cfg('0, '0, '0, '0);
      wr(A_RAW, '1);
      wr(A_MASKED, '1);
      wr(12'h420, '1);
      check_reg("R2", A_RAW, '0);
      check_reg("R2", A_MASKED, '0);
      check_reg("R2", 12'h420, '0);
   endtask

   task automatic t_rise();
      cfg('0, 8'h01, '0, '0);
      pin_in[0] = 1'b1;
      @(negedge clk);
      check_reg("R3", A_RAW, 8'h01);
      wr(A_CLEAR, 8'h01);
      pin_in[0] = 1'b0;
      @(negedge clk);
      check_reg("R3", A_RAW, 8'h00);
   endtask

   task automatic t_fall();
      cfg('0, 8'h00, '0, '0);
      pin_in[1] = 1'b1;
      @(negedge clk);
      check_reg("R4", A_RAW, 8'h00);
      pin_in[1] = 1'b0;
      @(negedge clk);
      check_reg("R4", A_RAW, 8'h02);
   endtask

   task automatic t_both();
      cfg(8'h04, 8'h00, '0, '0);
      pin_in[2] = 1'b1;
      @(negedge clk);
      check_reg("R5", A_RAW, 8'h04);
      wr(A_CLEAR, 8'h04);
      check_reg("R5", A_RAW, 8'h00);
      pin_in[2] = 1'b0;
      @(negedge clk);
      check_reg("R5", A_RAW, 8'h04);
   endtask

   task automatic t_dir();
      cfg(8'h08, '0, '0, '0);
      pin_is_input[3] = 1'b0;
      pin_in[3] = 1'b1;
      @(negedge clk);
      check_reg("R6", A_RAW, 8'h00);
      pin_in[3] = 1'b0;
      @(negedge clk);
      check_reg("R6", A_RAW, 8'h00);
      pin_is_input[3] = 1'b1;
   endtask

   task automatic t_level();
      cfg('0, 8'h10, '0, 8'h10);
      check_reg("R7", A_RAW, 8'h00);
      pin_in[4] = 1'b1;
      @(negedge clk);
      check_reg("R7", A_RAW, 8'h10);
      wr(A_CLEAR, 8'h10);
      check_reg("R7", A_RAW, 8'h10);
      pin_in[4] = 1'b0;
      @(negedge clk);
      wr(A_CLEAR, 8'h10);
      check_reg("R7", A_RAW, 8'h00);
      // level sensing on a pin marked as output, low level matches pol 0
      pin_is_input[5] = 1'b0;
      cfg('0, 8'h00, '0, 8'h20);
      check_reg("R7", A_RAW, 8'h20);
      cfg('0, '0, '0, '0);
      pin_is_input[5] = 1'b1;
      check_reg("R7", A_RAW, 8'h00);
   endtask

   task automatic t_clear();
      cfg(8'h03, '0, 8'h01, '0);
      pin_in[1:0] = 2'b11;
      @(negedge clk);
      check_reg("R8", A_RAW, 8'h03);
      check_reg("R10", A_MASKED, 8'h01);
      wr(A_CLEAR, 8'h02);
      check_reg("R8", A_RAW, 8'h01);
      wr(A_CLEAR, 8'h00);
      check_reg("R8", A_RAW, 8'h01);
      pin_in[1:0] = 2'b00;
      @(negedge clk);
      wr(A_CLEAR, '1);
   endtask

   task automatic t_race();
      cfg(8'h40, '0, '0, '0);
      pin_in[6] = 1'b1;
      wr(A_CLEAR, 8'h40);
      check_reg("R9", A_RAW, 8'h40);
      wr(A_CLEAR, 8'h40);
      check_reg("R9", A_RAW, 8'h00);
   endtask

   task automatic t_irq();
      cfg(8'h80, '0, 8'h80, '0);
      pin_in[7] = 1'b1;
      @(negedge clk);
      check_reg("R10", A_MASKED, 8'h80);
      check("R11", "irq same cycle as status", int'(irq), 0);
      @(negedge clk);
      check("R11", "irq one cycle later", int'(irq), 1);
      wr(A_MASK, 8'h00);
      check_reg("R10", A_MASKED, 8'h00);
      check("R11", "irq holds one cycle after unmask", int'(irq), 1);
      @(negedge clk);
      check("R11", "irq low after unmask", int'(irq), 0);
      wr(A_MASK, 8'h80);
      check("R11", "irq still low after remask", int'(irq), 0);
      @(negedge clk);
      check("R11", "irq high after remask", int'(irq), 1);
      wr(A_CLEAR, 8'h80);
      check_reg("R8", A_RAW, 8'h00);
      check("R11", "irq holds one cycle after clear", int'(irq), 1);
      @(negedge clk);
      check("R11", "irq low after clear", int'(irq), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_rise();
      t_fall();
      t_both();
      t_dir();
      t_level();
      t_clear();
      t_race();
      t_irq();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule